// File: doc/BRIEF.md
# Prioritized Interrupt Controller (63 sources)

This block gathers 63 level-sensitive interrupt request lines, numbered 1 to 63, and presents the processor with a single request. Each request passes through a per-source mask bit and a global mask-all switch. Among the requests that survive, the block selects one winner. The winner is the request with the highest programmed level; among equal levels it is the one with the highest priority. The block reports the winner's level as a 3-bit interrupt priority level and its identity as an 8-bit vector number. Both outputs are registered.

Software programs the block over a small synchronous register bus. The bus offers two 32-bit mask words, a read-only view of the raw request lines, and one byte-wide control register per source. Each control register holds a 3-bit level and a 3-bit priority. Sources 1 to 7 are hard-wired: source n always sits at level n with priority 4. The other 56 sources start out unassigned (level 0) and take no part in arbitration until software gives them a nonzero level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset both mask words read 0xFFFFFFFF, every programmable control register reads 0, and `ipl_o` and `vec_o` are both 0.
- R2: The mask word at address 0x00 covers sources 32..63, with source n at bit n-32. The mask word at 0x04 covers sources 1..31, with source n at bit n. Both are written with a word access (`bus_word`=1). A 1 blocks the source and a 0 lets it through. A byte access to either address changes nothing.
- R3: Bit 0 of the word at 0x04 is a mask-all switch. While it is 1, `ipl_o` is 0 whatever the other bits and requests hold.
- R4: The control register of source n sits at address 0x40+n and is written with a byte access (`bus_word`=0). Bits 5:3 hold the level and bits 2:0 hold the priority. Bits 7:6 read back as 0. A word access to this region changes nothing.
- R5: The control register of source n, for n in 1..7, always reads (n<<3)|4. Writes to it are ignored.
- R6: A source takes part in arbitration only if its request line is high, its mask bit is 0, and its level is nonzero. A source with level 0 is never selected, even when its priority is nonzero.
- R7: The winner is the participating source with the highest level. Among equal levels, the one with the highest priority wins.
- R8: When two participating sources have identical level and priority, the lower-numbered source wins.
- R9: One clock after the inputs settle, `ipl_o` holds the winner's level and `vec_o` holds 64 plus the winner's number. When there is no winner, both are 0.
- R10: Address 0x08 reads the request lines for sources 32..63, and address 0x0C reads the lines for sources 1..31, each at the same bit positions as the mask words. Bit 0 of 0x0C reads 0. Writes to these addresses do nothing.
- R11: Read data appears on `bus_rdata` one clock after the address is presented. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 64 | Request lines; bit n is source n, bit 0 is unused |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write enable |
| bus_word | input | 1 | 1 for a 32-bit access, 0 for a byte access |
| bus_wdata | input | 32 | Write data; byte accesses use bits 7:0 |
| bus_rdata | output | 32 | Registered read data |
| ipl_o | output | 3 | Winning level, 0 when there is no winner |
| vec_o | output | 8 | 64 plus the winning source number, 0 when there is no winner |

## Verification
The hardest cases to reach from the ports are two. One is an exact tie in both level and priority between two enabled sources. The other is a source that has a nonzero priority but a level of 0. Software would normally avoid both, so neither arises from ordinary programming. The stimulus first programs a deliberately conflicting control table that contains a duplicated level/priority pair and a level-0 entry. It then walks request patterns that pit those sources against each other and against the hard-wired sources. Mask-all and single-bit masks are then applied on top of request patterns that would otherwise produce a winner.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NSLOT  = 64;
    localparam int NFIX   = 7;
    localparam int LW     = 3;
    localparam int PW     = 3;
    localparam int CW     = LW + PW;
    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int IW     = $clog2(NSLOT);
    localparam int VW     = 8;
    localparam int VEC_BASE = 64;
    localparam int FIX_PRI  = 4;

    localparam logic [AW-1:0] A_MASK_HI = 8'h00;
    localparam logic [AW-1:0] A_MASK_LO = 8'h04;
    localparam logic [AW-1:0] A_PEND_HI = 8'h08;
    localparam logic [AW-1:0] A_PEND_LO = 8'h0C;
    localparam logic [AW-1:0] A_CTRL    = 8'h40;

    typedef logic [CW-1:0] ctrl_t;

    function automatic ctrl_t fixed_ctrl(input int n);
        return ctrl_t'((n << PW) | FIX_PRI);
    endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSLOT-1:0]          irq_req,
    input  logic [AW-1:0]             bus_addr,
    input  logic                      bus_we,
    input  logic                      bus_word,
    input  logic [DW-1:0]             bus_wdata,
    output logic [DW-1:0]             bus_rdata,
    output logic [NSLOT-1:0]          mask,
    output logic [NSLOT-1:0][CW-1:0]  ctrl
);
    localparam int FIRST_PROG = NFIX + 1;

    typedef struct packed {
        logic [NSLOT-1:0]                    mask;
        logic [NSLOT-1:FIRST_PROG][CW-1:0]   ctrl;
        logic [DW-1:0]                       rdata;
    } reg_st_t;

    reg_st_t st_d, st_q;

    logic          in_ctrl;
    logic [IW-1:0] idx;

    assign in_ctrl = (bus_addr[AW-1:IW] == A_CTRL[AW-1:IW]);
    assign idx     = bus_addr[IW-1:0];

    // Control view: slot 0 empty, fixed slots constant, rest stored
    for (genvar g = 0; g < NSLOT; g++) begin : g_view
        if (g == 0) begin : g_none
            assign ctrl[g] = '0;
        end else if (g <= NFIX) begin : g_fixed
            assign ctrl[g] = fixed_ctrl(g);
        end else begin : g_prog
            assign ctrl[g] = st_q.ctrl[g];
        end
    end

    always_comb begin
        st_d = st_q;
        if (bus_we) begin
            if (bus_word && bus_addr == A_MASK_HI) st_d.mask[NSLOT-1:DW] = bus_wdata;
            if (bus_word && bus_addr == A_MASK_LO) st_d.mask[DW-1:0]     = bus_wdata;
            if (!bus_word && in_ctrl && idx >= IW'(FIRST_PROG))
                st_d.ctrl[idx] = bus_wdata[CW-1:0];
        end
        st_d.rdata = '0;
        if (in_ctrl) begin
            st_d.rdata = DW'(ctrl[idx]);
        end else begin
            case (bus_addr)
                A_MASK_HI: st_d.rdata = st_q.mask[NSLOT-1:DW];
                A_MASK_LO: st_d.rdata = st_q.mask[DW-1:0];
                A_PEND_HI: st_d.rdata = irq_req[NSLOT-1:DW];
                A_PEND_LO: st_d.rdata = {irq_req[DW-1:1], 1'b0};
                default:   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask  <= '1;
            st_q.ctrl  <= '0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask      = st_q.mask;
    assign bus_rdata = st_q.rdata;

    // R2: low mask word only moves on a word write to its address
    a_r2_mask_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_word && bus_addr == A_MASK_LO) |=> $stable(st_q.mask[DW-1:0]));

    // R2: high mask word only moves on a word write to its address
    a_r2_mask_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_word && bus_addr == A_MASK_HI) |=> $stable(st_q.mask[NSLOT-1:DW]));

    // R4: a byte write to a programmable slot lands in that slot
    a_r4_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_word && in_ctrl && idx >= IW'(FIRST_PROG))
        |=> ctrl[$past(idx)] == $past(bus_wdata[CW-1:0]));
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic [NSLOT-1:0]          irq_req,
    input  logic [NSLOT-1:0]          mask,
    input  logic [NSLOT-1:0][CW-1:0]  ctrl,
    output logic                      win_valid,
    output logic [IW-1:0]             win_id,
    output logic [LW-1:0]             win_level
);
    logic [NSLOT-1:0] elig;

    for (genvar g = 0; g < NSLOT; g++) begin : g_elig
        if (g == 0) begin : g_slot0
            assign elig[g] = 1'b0 & irq_req[g] & (|ctrl[g]);
        end else begin : g_src
            assign elig[g] = irq_req[g] & ~mask[g] & ~mask[0]
                           & (ctrl[g][CW-1:PW] != '0);
        end
    end

    ctrl_t best_key;

    // Descending scan with >= lets the lower number win on a tie
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        best_key  = '0;
        for (int n = NSLOT - 1; n >= 1; n--) begin
            if (elig[n] && (!win_valid || ctrl[n] >= best_key)) begin
                win_valid = 1'b1;
                win_id    = IW'(n);
                best_key  = ctrl[n];
            end
        end
        win_level = best_key[CW-1:PW];
    end

    // R6: a reported winner always has a nonzero level
    always_comb begin
        a_r6_level_nonzero: assert (!win_valid || win_level != '0);
    end
endmodule

// File: rtl/irqc_present.sv
module irqc_present
    import irqc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           win_valid,
    input  logic [IW-1:0]  win_id,
    input  logic [LW-1:0]  win_level,
    output logic [LW-1:0]  ipl_o,
    output logic [VW-1:0]  vec_o
);
    typedef struct packed {
        logic [LW-1:0] ipl;
        logic [VW-1:0] vec;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (win_valid) begin
            st_d.ipl = win_level;
            st_d.vec = VW'(VEC_BASE) + VW'(win_id);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ipl_o = st_q.ipl;
    assign vec_o = st_q.vec;

    // R9: vector is zero exactly when no level is presented
    a_r9_idle_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (ipl_o == '0) == (vec_o == '0));

    // R9: active vector lies in 65..127
    a_r9_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        ipl_o != '0 |-> (vec_o > VW'(VEC_BASE) && vec_o < VW'(VEC_BASE + NSLOT)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [63:0]  irq_req,
    input  logic [7:0]   bus_addr,
    input  logic         bus_we,
    input  logic         bus_word,
    input  logic [31:0]  bus_wdata,
    output logic [31:0]  bus_rdata,
    output logic [2:0]   ipl_o,
    output logic [7:0]   vec_o
);
    logic [NSLOT-1:0]          mask_w;
    logic [NSLOT-1:0][CW-1:0]  ctrl_w;
    logic                      win_valid;
    logic [IW-1:0]             win_id;
    logic [LW-1:0]             win_level;

    irqc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mask      (mask_w),
        .ctrl      (ctrl_w)
    );

    irqc_arbiter u_arb (
        .irq_req   (irq_req),
        .mask      (mask_w),
        .ctrl      (ctrl_w),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_level (win_level)
    );

    irqc_present u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_level (win_level),
        .ipl_o     (ipl_o),
        .vec_o     (vec_o)
    );

    // R3: mask-all silences the next presented level
    a_r3_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
        mask_w[0] |=> ipl_o == '0);

    // R6: presented source was requesting and unmasked one cycle earlier
    a_r6_winner_live: assert property (@(posedge clk) disable iff (!rst_n)
        ipl_o != '0 |-> ((($past(irq_req & ~mask_w) >> vec_o[IW-1:0]) & 64'd1) != 64'd0));
endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_req = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_word = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  ipl_o;
    logic [7:0]  vec_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl u0 (.*);

    // {requests, expected level (4b), expected vector}
    localparam int NV = 12;
    localparam logic [75:0] TBL [NV] = '{
        {64'h0000_0000_0000_0400, 4'd3, 8'd74},   // R7 single L3
        {64'h0000_0000_0010_0400, 4'd5, 8'd84},   // R7 level beats
        {64'h0000_0100_0010_0000, 4'd5, 8'd104},  // R7 priority beats
        {64'h0004_0100_0000_0000, 4'd5, 8'd104},  // R8 tie -> lower
        {64'h0004_0000_0000_0000, 4'd5, 8'd114},  // R9 source 50
        {64'h0000_0002_0000_0000, 4'd0, 8'd0},    // R6 level 0 excluded
        {64'h8000_0000_0000_0080, 4'd7, 8'd127},  // R7 prio 7 over fixed 7
        {64'h0000_0000_0010_0080, 4'd7, 8'd71},   // R5 fixed level 7
        {64'h0000_0000_0000_0004, 4'd2, 8'd66},   // R5 fixed level 2
        {64'h0000_0000_0000_0001, 4'd0, 8'd0},    // R6 bit 0 no source
        {64'h0000_0000_0000_0420, 4'd5, 8'd69},   // R7 fixed 5 over L3
        {64'h0000_0000_0000_0000, 4'd0, 8'd0}     // R9 idle
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic word, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_word = word; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic apply(input logic [63:0] r);
        @(negedge clk);
        irq_req = r;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 ipl", 32'(ipl_o), 32'd0);
        check("R1 vec", 32'(vec_o), 32'd0);
        rd(8'h00, d); check("R1 mask hi", d, 32'hFFFF_FFFF);
        rd(8'h04, d); check("R1 mask lo", d, 32'hFFFF_FFFF);
        rd(8'h4A, d); check("R1 ctrl10", d, 32'h0);
        // R5 fixed control readback
        rd(8'h45, d); check("R5 ctrl5", d, 32'h2C);
        // R3 reset masks block a live request
        apply(64'h20);
        check("R3 reset masked", 32'(ipl_o), 32'd0);
        apply(64'h0);

        // program table and unmask
        wr(8'h4A, 1'b0, 32'h1A);
        wr(8'h54, 1'b0, 32'h29);
        wr(8'h68, 1'b0, 32'h2E);
        wr(8'h72, 1'b0, 32'h2E);
        wr(8'h61, 1'b0, 32'h05);
        wr(8'h7F, 1'b0, 32'h3F);
        wr(8'h00, 1'b1, 32'h0);
        wr(8'h04, 1'b1, 32'h0);

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i][75:12]);
            check($sformatf("R9 vec%0d ipl", i), 32'(ipl_o), 32'(TBL[i][11:8]));
            check($sformatf("R9 vec%0d vec", i), 32'(vec_o), 32'(TBL[i][7:0]));
        end

        // R9 one-cycle latency: change lands after exactly one edge
        @(negedge clk); irq_req = 64'h400;
        @(posedge clk); #1;
        check("R9 latency", 32'(vec_o), 32'd74);

        // R3 mask-all
        wr(8'h04, 1'b1, 32'h1);
        apply(64'h8000_0000_0000_0400);
        check("R3 mask all", 32'(ipl_o), 32'd0);
        wr(8'h04, 1'b1, 32'h0);

        // R2 mask single high source 63
        wr(8'h00, 1'b1, 32'h8000_0000);
        apply(64'h8000_0000_0000_0004);
        check("R2 mask hi bit", 32'(vec_o), 32'd66);
        wr(8'h00, 1'b1, 32'h0);
        // R2 mask single low source 2
        wr(8'h04, 1'b1, 32'h4);
        apply(64'h0000_0000_0000_0404);
        check("R2 mask lo bit", 32'(vec_o), 32'd74);
        // R2 byte write to mask ignored
        wr(8'h04, 1'b0, 32'hFF);
        rd(8'h04, d); check("R2 byte ignored", d, 32'h4);
        wr(8'h04, 1'b1, 32'h0);

        // R10 pending view
        apply(64'h8000_0000_0000_0401);
        rd(8'h08, d); check("R10 pend hi", d, 32'h8000_0000);
        rd(8'h0C, d); check("R10 pend lo", d, 32'h400);
        wr(8'h0C, 1'b1, 32'hFFFF_FFFF);
        rd(8'h0C, d); check("R10 pend write", d, 32'h400);
        apply(64'h0);

        // R4 word write ignored, upper bits read 0
        wr(8'h4A, 1'b1, 32'h3F);
        rd(8'h4A, d); check("R4 word ignored", d, 32'h1A);
        wr(8'h4B, 1'b0, 32'hFF);
        rd(8'h4B, d); check("R4 bits 7:6", d, 32'h3F);
        // R5 fixed write ignored
        wr(8'h43, 1'b0, 32'h3F);
        rd(8'h43, d); check("R5 fixed write", d, 32'h1C);
        // R11 unmapped
        rd(8'h20, d); check("R11 unmapped", d, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule